// File: doc/BRIEF.md
# RAM Debug Nibble Viewer

This block gives a bench-side or board-side user a way to look inside the small SPI-writable RAM without going through the serial bus. A group of switches supplies a byte address, and another switch picks one half of that byte. The block drives the switch address onto the memory's read port. Each time the single-step button produces a rising edge on the debug clock, the block captures the chosen four-bit half.

The captured value stays in place until the next press. It drives a seven-segment hex display and also appears on four output pins. The display's decimal point is not part of the captured value. It follows the bus chip-select line at all times, so the user can see at a glance whether a transaction is open.

The RAM runs on the serial clock and the viewer runs on the debug clock. The byte is taken as a quasi-static value, on the assumption that no write is in progress when the button is pressed.

Top module: `ram_nibble_viewer`

## Requirements
- R1: `ram_rd_addr` always equals `sel_addr`, so each switch setting addresses one of the RAM bytes.
- R2: With `sel_nib` = 0, a debug clock rising edge captures bits [3:0] of `ram_rd_data`.
- R3: With `sel_nib` = 1, a debug clock rising edge captures bits [7:4] of `ram_rd_data`.
- R4: The captured value changes only on a rising edge of `dbg_clk`. Changes to `sel_addr`, `sel_nib` or the RAM data between edges leave `nib_out` and `seg_out` unchanged.
- R5: `seg_out` is active high, with bit 0 = segment a through bit 6 = segment g. It shows the captured value as hex using these codes: 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 b:7C C:39 d:5E E:79 F:71.
- R6: `nib_out` carries the captured value and updates on the same edge as `seg_out`.
- R7: `dp_out` equals `spi_cs_n` at all times, with no clock involved.
- R8: When `rst` is high at a `dbg_clk` rising edge, the next outputs are `nib_out` = 0 and `seg_out` = 3F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dbg_clk | input | 1 | Single-step debug clock from the button |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Bus chip-select, shown on the decimal point |
| sel_addr | input | 3 | Byte address switches |
| sel_nib | input | 1 | Half select: 0 low, 1 high |
| ram_rd_addr | output | 3 | Read address to the RAM read port |
| ram_rd_data | input | 8 | Byte returned by the RAM read port |
| seg_out | output | 7 | Segments a..g, active high |
| dp_out | output | 1 | Decimal point, follows chip-select |
| nib_out | output | 4 | Captured half-byte on the output pins |

## Verification
The bench builds the block with its defaults: a 3-bit address, an 8-bit byte and a 4-bit field. With these values all eight addresses and both halves can be swept exhaustively. It also pushes every one of the sixteen field values through each half, so every display code is reached in both positions. Random RAM contents and switch settings are mixed in. Between presses, the bench changes the switches and the RAM contents and then confirms that the outputs hold.

// File: rtl/nview_pkg.sv
package nview_pkg;
  // Segment patterns, bit 0 = a ... bit 6 = g, active high
  function automatic logic [6:0] hex_to_seg(input logic [3:0] v);
    logic [6:0] s;
    case (v)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/nview_pick.sv
module nview_pick #(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4,
  localparam int NPARTS = BYTE_W / NIB_W,
  localparam int SEL_W  = (NPARTS > 1) ? $clog2(NPARTS) : 1
) (
  input  logic [BYTE_W-1:0] word_in,
  input  logic [SEL_W-1:0]  part_sel,
  output logic [NIB_W-1:0]  part_out
);
  logic [NIB_W-1:0] parts [NPARTS];

  for (genvar g = 0; g < NPARTS; g++) begin : g_part
    assign parts[g] = word_in[g*NIB_W +: NIB_W];
  end

  always_comb begin
    part_out = parts[0];
    for (int i = 0; i < NPARTS; i++) begin
      if (part_sel == SEL_W'(i)) part_out = parts[i];
    end
  end
endmodule

// File: rtl/nview_seg7.sv
module nview_seg7 (
  input  logic [3:0] value,
  output logic [6:0] segs
);
  import nview_pkg::*;
  always_comb segs = hex_to_seg(value);
endmodule

// File: rtl/nview_hold.sv
module nview_hold #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RST_VAL;
    else     q <= d;
  end
endmodule

// File: rtl/ram_nibble_viewer.sv
module ram_nibble_viewer #(
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4,
  localparam int NPARTS = BYTE_W / NIB_W,
  localparam int SEL_W  = (NPARTS > 1) ? $clog2(NPARTS) : 1
) (
  input  logic              dbg_clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic [SEL_W-1:0]  sel_nib,
  output logic [ADDR_W-1:0] ram_rd_addr,
  input  logic [BYTE_W-1:0] ram_rd_data,
  output logic [6:0]        seg_out,
  output logic              dp_out,
  output logic [NIB_W-1:0]  nib_out
);
  localparam logic [6:0] SEG_ZERO = 7'h3F;

  logic [NIB_W-1:0] picked;
  logic [6:0]       seg_next;

  assign ram_rd_addr = sel_addr;
  assign dp_out      = spi_cs_n;

  nview_pick #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_pick (
    .word_in (ram_rd_data),
    .part_sel(sel_nib),
    .part_out(picked)
  );

  nview_seg7 u_seg (
    .value(picked[3:0]),
    .segs (seg_next)
  );

  nview_hold #(.W(NIB_W), .RST_VAL('0)) u_nib_reg (
    .clk(dbg_clk), .rst(rst), .d(picked), .q(nib_out)
  );

  nview_hold #(.W(7), .RST_VAL(SEG_ZERO)) u_seg_reg (
    .clk(dbg_clk), .rst(rst), .d(seg_next), .q(seg_out)
  );
endmodule

// File: rtl/nview_chk.sv
module nview_chk #(
  parameter int ADDR_W = 3,
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4,
  localparam int NPARTS = BYTE_W / NIB_W,
  localparam int SEL_W  = (NPARTS > 1) ? $clog2(NPARTS) : 1
) (
  input logic              dbg_clk,
  input logic              rst,
  input logic              spi_cs_n,
  input logic [ADDR_W-1:0] sel_addr,
  input logic [SEL_W-1:0]  sel_nib,
  input logic [ADDR_W-1:0] ram_rd_addr,
  input logic [BYTE_W-1:0] ram_rd_data,
  input logic [6:0]        seg_out,
  input logic              dp_out,
  input logic [NIB_W-1:0]  nib_out
);
  function automatic logic [6:0] ref_seg(input logic [3:0] v);
    logic [15:0][6:0] t;
    t = {7'h71, 7'h79, 7'h5E, 7'h39, 7'h7C, 7'h77, 7'h6F, 7'h7F,
         7'h07, 7'h7D, 7'h6D, 7'h66, 7'h4F, 7'h5B, 7'h06, 7'h3F};
    return t[v];
  endfunction

  logic [NIB_W-1:0] want_nib;
  always_comb want_nib = ram_rd_data[sel_nib*NIB_W +: NIB_W];

  assert_reset_state_R8: assert property (@(posedge dbg_clk)
    rst |=> (nib_out == '0 && seg_out == 7'h3F));

  assert_capture_R2_R3: assert property (@(posedge dbg_clk) disable iff (rst)
    !rst |=> nib_out == $past(want_nib));

  assert_seg_code_R5: assert property (@(posedge dbg_clk) disable iff (rst)
    seg_out == ref_seg(nib_out[3:0]));

  assert_read_addr_R1: assert property (@(posedge dbg_clk)
    ram_rd_addr == sel_addr);

  assert_dp_follow_R7: assert property (@(negedge dbg_clk)
    dp_out == spi_cs_n);
endmodule

bind ram_nibble_viewer nview_chk #(
  .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NIB_W(NIB_W)
) u_nview_chk (
  .dbg_clk(dbg_clk), .rst(rst), .spi_cs_n(spi_cs_n), .sel_addr(sel_addr),
  .sel_nib(sel_nib), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
  .seg_out(seg_out), .dp_out(dp_out), .nib_out(nib_out)
);

// File: tb/test_ram_nibble_viewer.sv
module test_ram_nibble_viewer;
  logic       dbg_clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_cs_n = 1'b1;
  logic [2:0] sel_addr = '0;
  logic [0:0] sel_nib = '0;
  logic [2:0] ram_rd_addr;
  logic [7:0] ram_rd_data;
  logic [6:0] seg_out;
  logic       dp_out;
  logic [3:0] nib_out;
  logic [7:0] mem [8];

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  assign ram_rd_data = mem[ram_rd_addr];

  ram_nibble_viewer i_ram_nibble_viewer (
    .dbg_clk(dbg_clk), .rst(rst), .spi_cs_n(spi_cs_n), .sel_addr(sel_addr),
    .sel_nib(sel_nib), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data),
    .seg_out(seg_out), .dp_out(dp_out), .nib_out(nib_out)
  );

  function automatic logic [6:0] exp_seg(input logic [3:0] v);
    case (v)
      4'h0: return 7'h3F; 4'h1: return 7'h06; 4'h2: return 7'h5B; 4'h3: return 7'h4F;
      4'h4: return 7'h66; 4'h5: return 7'h6D; 4'h6: return 7'h7D; 4'h7: return 7'h07;
      4'h8: return 7'h7F; 4'h9: return 7'h6F; 4'hA: return 7'h77; 4'hB: return 7'h7C;
      4'hC: return 7'h39; 4'hD: return 7'h5E; 4'hE: return 7'h79; default: return 7'h71;
    endcase
  endfunction

  function automatic logic [3:0] exp_nib(input logic [7:0] b, input logic s);
    return s ? b[7:4] : b[3:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // 250 MHz press: 2 ns high, 2 ns low; outputs sampled while low
  task automatic press();
    dbg_clk = 1'b1; #2;
    dbg_clk = 1'b0; #2;
  endtask

  task automatic capture_and_check(input logic [2:0] a, input logic s, input string req);
    logic [3:0] e;
    sel_addr = a; sel_nib = s; #1;
    check("R1 read address", 32'(ram_rd_addr), 32'(a));
    e = exp_nib(mem[a], s);
    press();
    check(req, 32'(nib_out), 32'(e));
    check("R5/R6 segments", 32'(seg_out), 32'(exp_seg(e)));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 8; i++) mem[i] = 8'(i * 8'h1D + 8'h40);
    #1;
    press(); press();
    check("R8 reset nib", 32'(nib_out), 32'h0);
    check("R8 reset seg", 32'(seg_out), 32'h3F);
    rst = 1'b0;

    // R7: decimal point follows chip-select without a clock
    spi_cs_n = 1'b0; #1;
    check("R7 dp low", 32'(dp_out), 32'h0);
    spi_cs_n = 1'b1; #1;
    check("R7 dp high", 32'(dp_out), 32'h1);

    // R2/R3: every value through both halves at every address
    for (int a = 0; a < 8; a++) begin
      for (int v = 0; v < 16; v++) begin
        mem[a] = {4'(15 - v), 4'(v)};
        capture_and_check(3'(a), 1'b0, "R2 low half");
        capture_and_check(3'(a), 1'b1, "R3 high half");
      end
    end

    // R4: hold between presses
    mem[5] = 8'hA7;
    capture_and_check(3'd5, 1'b1, "R3 high half");
    sel_addr = 3'd2; sel_nib = 1'b0; mem[5] = 8'h3C; mem[2] = 8'h51; #3;
    check("R4 hold nib", 32'(nib_out), 32'hA);
    check("R4 hold seg", 32'(seg_out), 32'(exp_seg(4'hA)));

    // Random mix
    for (int k = 0; k < 300; k++) begin
      logic [2:0] ra;
      logic rs;
      ra = 3'($urandom);
      rs = 1'($urandom);
      mem[$urandom % 8] = 8'($urandom);
      spi_cs_n = 1'($urandom); #1;
      check("R7 dp random", 32'(dp_out), 32'(spi_cs_n));
      capture_and_check(ra, rs, rs ? "R3 random" : "R2 random");
    end

    // R8 again after activity
    mem[0] = 8'hFF; sel_addr = 3'd0; rst = 1'b1;
    press();
    check("R8 reset nib late", 32'(nib_out), 32'h0);
    check("R8 reset seg late", 32'(seg_out), 32'h3F);
    rst = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule